// File: doc/BRIEF.md
# Power-Managed ADC Sampling Controller

This block sequences a serial sampling converter that is put to sleep by cutting a frame short. It drives chip select and the serial clock, shifts in 16 data bits per frame, and returns one sample per request on a result bus with a single-cycle strobe. The serial clock is derived from the system clock. Its high and low phases each last `CLK_DIV` system cycles. Between any two frames chip select stays high for a quiet gap of `QUIET_CYC` cycles.

The converter may come out of power-up in either mode. For that reason the controller first runs one dummy frame after reset and discards it. It then puts the converter to sleep. Each request taken while the converter sleeps runs four steps in order: a full dummy frame that wakes the converter, a quiet gap, a full valid frame whose data is returned, and a short frame that puts the converter back to sleep. When the continuous input is high, the controller skips the sleep step and leaves the converter awake, so that a later request needs only the valid frame. A system that needs more than about 350 ksps should run this way. A request that arrives while a sequence runs is held, and it starts once the controller returns to idle.

Top module: `adc_sample_seq`

## Requirements
- R1: While reset is low, chip select and the serial clock are high and the result strobe is low. After reset the controller runs one full dummy frame with no result strobe. When continuous is low, a shutdown frame follows.
- R2: A full frame has exactly 16 serial clock falling edges. Falling edges are 2*CLK_DIV system cycles apart. The serial clock is high whenever chip select is high and when chip select falls.
- R3: A shutdown frame raises chip select after the 4th falling edge and before a 5th.
- R4: Chip select stays high for at least QUIET_CYC cycles between the end of one frame and the start of the next.
- R5: A request taken while the converter sleeps produces, in order: full dummy frame, full valid frame, and (continuous low) a shutdown frame.
- R6: Data is captured MSB first, with one bit at each falling edge of the valid frame. The result bus then holds the 16 bits, bit 15 being the first bit captured. The result strobe is high for one cycle per request and never for dummy frames.
- R7: With continuous high no shutdown frame follows a sample. A request taken while the converter is awake produces only one full valid frame.
- R8: When continuous is low and the converter is awake while the controller is idle, a shutdown frame starts without any request.
- R9: A request that arrives while busy is served by a complete sequence after the current one ends.
- R10: Busy rises in the cycle after a request is accepted and stays high until the controller returns to idle. This covers the final quiet gap. Chip select is never low while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Sample request pulse |
| continuous | input | 1 | Keep converter awake between samples |
| sdata | input | 1 | Serial data from converter |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Sequence in progress |
| result | output | 16 | Last valid sample |
| result_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench models the converter. It feeds a fresh random word into every frame and logs the number of falling edges each frame contains. The log is compared with a sequence the bench computes from the sleep state, the continuous setting and the number of requests. A design that cuts the shutdown frame at the wrong edge, or leaves out the wake-up dummy, shows up as a wrong frame length or a wrong frame count. Other faults surface in the data. A result taken from the dummy frame, or with its bits in the wrong order, fails the word comparison. A dropped pending request or an extra strobe fails the strobe count. A missed spontaneous shutdown after continuous is cleared leaves the log empty.

// File: rtl/adc_sample_seq.sv
module adc_sample_seq #(
  parameter int CLK_DIV    = 2,
  parameter int QUIET_CYC  = 5,
  parameter int FRAME_BITS = 16,
  parameter int SHDN_EDGE  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  continuous,
  input  logic                  sdata,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  busy,
  output logic [FRAME_BITS-1:0] result,
  output logic                  result_valid
);
  localparam int CMAX = (CLK_DIV > QUIET_CYC) ? CLK_DIV : QUIET_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int EW   = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} st_t;
  typedef enum logic [1:0] {K_BOOT, K_DUMMY, K_VALID, K_SHDN} kind_t;

  st_t                   st;
  kind_t                 kind, nk;
  logic [CW-1:0]         cnt;
  logic [EW-1:0]         edges;
  logic [FRAME_BITS-1:0] shreg;
  logic                  awake, serving, pend, launch, to_idle;

  wire want     = req | pend;
  wire tick     = (cnt == CW'(CLK_DIV - 1));
  wire gap_done = (cnt == CW'(QUIET_CYC - 1));
  wire [EW-1:0] last_edge = (kind == K_SHDN) ? EW'(SHDN_EDGE) : EW'(FRAME_BITS);

  assign busy = (st != S_IDLE);

  always_comb begin
    launch  = 1'b0;
    to_idle = 1'b0;
    nk      = K_DUMMY;
    case (st)
      S_IDLE:
        if (want) begin
          launch = 1'b1;
          nk     = awake ? K_VALID : K_DUMMY;
        end else if (awake && !continuous) begin
          launch = 1'b1;
          nk     = K_SHDN;
        end
      S_GAP:
        if (gap_done) begin
          case (kind)
            K_BOOT:  launch = 1'b1;
            K_DUMMY:
              if (serving) begin
                launch = 1'b1;
                nk     = K_VALID;
              end else if (continuous) to_idle = 1'b1;
              else begin
                launch = 1'b1;
                nk     = K_SHDN;
              end
            K_VALID:
              if (continuous) to_idle = 1'b1;
              else begin
                launch = 1'b1;
                nk     = K_SHDN;
              end
            default: to_idle = 1'b1;
          endcase
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_GAP;
      kind         <= K_BOOT;
      cnt          <= '0;
      edges        <= '0;
      shreg        <= '0;
      cs_n         <= 1'b1;
      sclk         <= 1'b1;
      result       <= '0;
      result_valid <= 1'b0;
      awake        <= 1'b0;
      serving      <= 1'b0;
      pend         <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (want) begin
          pend    <= 1'b0;
          serving <= 1'b1;
        end
      end else if (req) pend <= 1'b1;

      if (launch) begin
        st    <= S_FRAME;
        kind  <= nk;
        cs_n  <= 1'b0;
        cnt   <= '0;
        edges <= '0;
      end else if (to_idle) begin
        st      <= S_IDLE;
        serving <= 1'b0;
        cnt     <= '0;
      end else if (st == S_GAP) begin
        cnt <= cnt + 1'b1;
      end else if (st == S_FRAME) begin
        if (!tick) cnt <= cnt + 1'b1;
        else begin
          cnt <= '0;
          if (sclk) begin
            sclk  <= 1'b0;
            edges <= edges + 1'b1;
            shreg <= {shreg[FRAME_BITS-2:0], sdata};
          end else if (edges == last_edge) begin
            sclk <= 1'b1;
            cs_n <= 1'b1;
            st   <= S_GAP;
            if (kind == K_VALID) begin
              result       <= shreg;
              result_valid <= 1'b1;
            end
            if (kind == K_DUMMY) awake <= 1'b1;
            if (kind == K_SHDN)  awake <= 1'b0;
          end else begin
            sclk <= 1'b1;
          end
        end
      end
    end
  end

  initial begin
    assert_shdn_edge_R3: assert (SHDN_EDGE > 2 && SHDN_EDGE < 10 && SHDN_EDGE < FRAME_BITS);
  end

  assert_idle_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk);
  assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (edges == EW'(FRAME_BITS) || edges == EW'(SHDN_EDGE)));
  assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  assert_strobe_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> busy);
  assert_cs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
endmodule

// File: tb/adc_sample_seq_test.sv
module adc_sample_seq_test;
  localparam int DIV = 2;
  localparam int QUIET = 5;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, continuous = 1'b0, sdata = 1'b0;
  logic cs_n, sclk, busy, result_valid;
  logic [15:0] result;

  adc_sample_seq #(.CLK_DIV(DIV), .QUIET_CYC(QUIET), .FRAME_BITS(16), .SHDN_EDGE(4)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .continuous(continuous), .sdata(sdata),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .result(result), .result_valid(result_valid));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int log_n = 0, log_len[32];
  logic [15:0] log_word[32];
  int exp_n, exp_len[32], exp_vidx;
  int nvalid = 0;
  logic [15:0] last_result;
  int idx = 0, gap = 0, min_gap = 1000, since_fall = 0, bad_spacing = 0, bad_busy = 0;
  logic [15:0] word;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  bit model_awake = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (!busy && !cs_n) bad_busy++;
      if (result_valid) begin
        nvalid++;
        last_result = result;
      end
      since_fall++;
      if (prev_cs && !cs_n) begin
        if (gap < min_gap) min_gap = gap;
        word = 16'($urandom);
        idx = 0;
        sdata = word[15];
      end else if (!cs_n && prev_sclk && !sclk) begin
        if (idx > 0 && since_fall != 2 * DIV) bad_spacing++;
        since_fall = 0;
        idx++;
        sdata = (idx < 16) ? word[15 - idx] : 1'b0;
      end else if (!prev_cs && cs_n) begin
        if (log_n < 32) begin
          log_len[log_n] = idx;
          log_word[log_n] = word;
        end
        log_n++;
        gap = 0;
      end
      if (cs_n) gap++;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clear_log();
    log_n = 0;
    nvalid = 0;
    exp_n = 0;
    exp_vidx = -1;
  endtask

  function automatic void add_exp(int len);
    if (exp_n < 32) exp_len[exp_n] = len;
    exp_n++;
  endfunction

  function automatic void expect_prefix(bit cont);
    if (model_awake && !cont) begin
      add_exp(4);
      model_awake = 0;
    end
  endfunction

  function automatic void expect_req(bit cont);
    if (!model_awake) add_exp(16);
    exp_vidx = exp_n;
    add_exp(16);
    if (cont) model_awake = 1;
    else begin
      add_exp(4);
      model_awake = 0;
    end
  endfunction

  task automatic pulse_req();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet_run = 0;
    for (int t = 0; t < 20000 && quiet_run < QUIET + 6; t++) begin
      @(negedge clk);
      quiet_run = busy ? 0 : quiet_run + 1;
    end
    check(quiet_run >= QUIET + 6, "R10 idle timeout", quiet_run, QUIET + 6);
  endtask

  task automatic compare(input string tag, input int nreq);
    int bad = -1;
    check(log_n == exp_n, {tag, " frame count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n && i < 32; i++)
      if (bad < 0 && log_len[i] != exp_len[i]) bad = i;
    check(bad < 0, {tag, " frame lengths"}, bad < 0 ? 0 : log_len[bad], bad < 0 ? 0 : exp_len[bad]);
    check(nvalid == nreq, "R6 strobe count", nvalid, nreq);
    if (exp_vidx >= 0 && exp_vidx < log_n && exp_vidx < 32)
      check(last_result == log_word[exp_vidx], "R6 result word", last_result, log_word[exp_vidx]);
  endtask

  initial begin
    void'($urandom(32'd4631));
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b1, "R1 reset lines", {cs_n, sclk}, 3);
    check(result_valid === 1'b0, "R1 reset strobe", result_valid, 0);
    clear_log();
    rst_n = 1'b1;
    add_exp(16);
    add_exp(4);
    wait_idle();
    compare("R1 boot", 0);

    clear_log();
    expect_req(0);
    pulse_req();
    check(busy === 1'b1, "R10 busy after accept", busy, 1);
    wait_idle();
    compare("R5 sleep request", 1);

    clear_log();
    expect_req(0);
    expect_req(0);
    pulse_req();
    repeat (20) @(negedge clk);
    pulse_req();
    wait_idle();
    compare("R9 pending", 2);

    clear_log();
    continuous = 1'b1;
    expect_req(1);
    pulse_req();
    wait_idle();
    compare("R7 continuous wake", 1);
    clear_log();
    expect_req(1);
    pulse_req();
    wait_idle();
    compare("R7 awake request", 1);

    clear_log();
    continuous = 1'b0;
    expect_prefix(0);
    wait_idle();
    compare("R8 spontaneous shutdown", 0);

    for (int it = 0; it < 25; it++) begin
      bit c = 1'($urandom);
      bit two = 1'($urandom);
      clear_log();
      @(negedge clk) continuous = c;
      expect_prefix(c);
      repeat (3) @(negedge clk);
      expect_req(c);
      pulse_req();
      if (two) begin
        repeat (10 + $urandom % 20) @(negedge clk);
        expect_req(c);
        pulse_req();
      end
      wait_idle();
      compare("R5 random", two ? 2 : 1);
    end

    check(bad_spacing == 0, "R2 edge spacing", bad_spacing, 0);
    check(min_gap >= QUIET, "R4 quiet gap", min_gap, QUIET);
    check(bad_busy == 0, "R10 cs while idle", bad_busy, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule